// File: doc/BRIEF.md
# Accumulator ALU with flags

This block is the arithmetic and logic datapath of a small accumulator-based controller. An 8-bit accumulator value and a second operand byte arrive each cycle together with a 4-bit operation select. The block returns the result byte combinationally. It keeps the carry, half-carry and signed-overflow flags in a three-bit register. Arithmetic, rotate-through-carry and decimal-adjust operations read the stored carry and half-carry flags.

The surrounding core fetches the operands and writes the result wherever it belongs. The core raises `exec_en` in the cycle whose operation must commit its flags. There is no back-pressure. The block has no ready signal and can take a new operation in every cycle. The result output always reflects the present inputs and the stored flags. Flags change only on a clock edge where `exec_en` is high.

Top module: `acc_alu_unit`

## Requirements
- R1: After reset is asserted (`rst_n` low), the carry, half-carry and overflow flags all read 0.
- R2: Code 0 (add) gives `result = (acc + src) mod 256`. Code 1 (add with carry) gives `result = (acc + src + CY) mod 256`. For both, CY becomes 1 exactly when the true sum exceeds 255.
- R3: On codes 0 and 1, AC becomes the carry out of bit 3 (low nibbles plus carry-in exceed 15). OV becomes 1 when the sum of the operands read as signed bytes, plus carry-in, falls outside -128..127.
- R4: Code 2 (subtract with borrow) gives `result = (acc - src - CY) mod 256`. CY becomes 1 when the true difference is negative. AC becomes 1 when the low-nibble difference with CY is negative. OV becomes 1 when the signed difference falls outside -128..127.
- R5: Codes 3, 4 and 5 give bitwise AND, OR and XOR of acc and src. Code 6 gives the one's complement of acc. None of them changes any flag.
- R6: Code 7 rotates acc right one place, with bit 0 entering bit 7. Code 8 rotates acc left one place, with bit 7 entering bit 0. Neither changes any flag.
- R7: Code 9 rotates right through carry: bit 0 goes to CY and the old CY enters bit 7. Code 10 rotates left through carry: bit 7 goes to CY and the old CY enters bit 0. AC and OV are unchanged.
- R8: Code 11 exchanges the two nibbles of acc and leaves the flags unchanged.
- R9: Code 12 (decimal adjust) first adds 06h when the low nibble of acc exceeds 9 or AC is 1. It then adds 60h when the high nibble of that intermediate value exceeds 9, when CY is 1, or when the first step carried out.
- R10: Code 12 sets CY when either correction step carries out past bit 7. It never clears CY, and it leaves AC and OV unchanged.
- R11: Code 13 gives `(acc + 1) mod 256` and code 14 gives `(acc - 1) mod 256`. Neither changes any flag.
- R12: With `exec_en` low, the flags hold their value while `result` still shows the selected operation's value.
- R13: Code 15 passes acc through unchanged and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| exec_en | input | 1 | Commit the selected operation's flags on this edge |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| src_in | input | 8 | Second operand |
| result | output | 8 | Combinational result byte |
| cy_flag | output | 1 | Stored carry / borrow flag |
| ac_flag | output | 1 | Stored half-carry flag |
| ov_flag | output | 1 | Stored signed overflow flag |

## Verification
The hardest cases to reach are those where an operation's result depends on flag values left behind by an earlier operation. Examples are a decimal adjust with AC set but CY clear, and a subtract entering with a pending borrow. The flags have no load path, so they cannot be written directly. Before each tested operation, the bench therefore issues a priming add whose operands produce each of the four carry/half-carry combinations. It sweeps every accumulator value under each combination and cross-checks the flags the priming add itself produced.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_CPL  = 4'd6,
    OP_RR   = 4'd7,
    OP_RL   = 4'd8,
    OP_RRC  = 4'd9,
    OP_RLC  = 4'd10,
    OP_SWAP = 4'd11,
    OP_DA   = 4'd12,
    OP_INC  = 4'd13,
    OP_DEC  = 4'd14,
    OP_PASS = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flag_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              cy,
  output logic              ac,
  output logic              ov
);

  localparam int LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [NIB_W:0]    nib_sum;
  logic [LOW_W:0]    low_sum;
  logic [DATA_W:0]   full_sum;

  // Subtraction reuses the adder: a - b - c == a + ~b + (1 - c)
  assign b_eff = sub ? ~b : b;
  assign c_eff = sub ? ~cin : cin;

  assign nib_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                  + {{NIB_W{1'b0}}, c_eff};
  assign low_sum  = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                  + {{LOW_W{1'b0}}, c_eff};
  assign full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};

  assign sum = full_sum[DATA_W-1:0];
  // A borrow is the inverse of the adder carry
  assign cy  = sub ? ~full_sum[DATA_W] : full_sum[DATA_W];
  assign ac  = sub ? ~nib_sum[NIB_W]   : nib_sum[NIB_W];
  // Inversion on both sides cancels in the XOR
  assign ov  = low_sum[LOW_W] ^ full_sum[DATA_W];

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops import acc_alu_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] res,
  output logic              cy
);

  logic [DATA_W-1:0] swapped;

  // Exchange the upper and lower halves, one nibble lane at a time
  for (genvar g = 0; g < NIB_W; g++) begin : g_swap
    assign swapped[g]         = a[g + NIB_W];
    assign swapped[g + NIB_W] = a[g];
  end

  always_comb begin
    res = a;
    cy  = cin;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CPL:  res = ~a;
      OP_RR:   res = {a[0], a[DATA_W-1:1]};
      OP_RL:   res = {a[DATA_W-2:0], a[DATA_W-1]};
      OP_RRC: begin
        res = {cin, a[DATA_W-1:1]};
        cy  = a[0];
      end
      OP_RLC: begin
        res = {a[DATA_W-2:0], cin};
        cy  = a[DATA_W-1];
      end
      OP_SWAP: res = swapped;
      OP_INC:  res = a + DATA_W'(1);
      OP_DEC:  res = a - DATA_W'(1);
      default: res = a;
    endcase
  end

endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cy_in,
  input  logic              ac_in,
  output logic [DATA_W-1:0] res,
  output logic              cy_out
);

  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
  localparam logic [DATA_W:0]  LO_STEP   = (DATA_W+1)'(6);
  localparam logic [DATA_W:0]  HI_STEP   = (DATA_W+1)'(6) << NIB_W;

  logic            lo_fix;
  logic            hi_fix;
  logic [DATA_W:0] step1;
  logic [DATA_W:0] step2;

  assign lo_fix = (a[NIB_W-1:0] > DIGIT_MAX) | ac_in;
  assign step1  = {1'b0, a} + (lo_fix ? LO_STEP : '0);
  assign hi_fix = (step1[DATA_W-1:NIB_W] > DIGIT_MAX) | cy_in | step1[DATA_W];
  assign step2  = {1'b0, step1[DATA_W-1:0]} + (hi_fix ? HI_STEP : '0);

  assign res    = step2[DATA_W-1:0];
  assign cy_out = cy_in | step1[DATA_W] | step2[DATA_W];

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit import acc_alu_pkg::*; #(
  parameter int DATA_W = BYTE_W,
  parameter int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] src_in,
  output logic [DATA_W-1:0] result,
  output logic              cy_flag,
  output logic              ac_flag,
  output logic              ov_flag
);

  alu_op_e           op;
  flag_t             flags_q;
  flag_t             flags_d;
  logic              is_sub;
  logic              arith_cin;
  logic [DATA_W-1:0] arith_res;
  logic              arith_cy;
  logic              arith_ac;
  logic              arith_ov;
  logic [DATA_W-1:0] bit_res;
  logic              bit_cy;
  logic [DATA_W-1:0] da_res;
  logic              da_cy;

  assign op        = alu_op_e'(op_sel);
  assign is_sub    = (op == OP_SUBB);
  assign arith_cin = (op == OP_ADD) ? 1'b0 : flags_q.cy;

  alu_arith #(.DATA_W(DATA_W), .NIB_W(HALF_W)) u_arith (
    .a   (acc_in),
    .b   (src_in),
    .cin (arith_cin),
    .sub (is_sub),
    .sum (arith_res),
    .cy  (arith_cy),
    .ac  (arith_ac),
    .ov  (arith_ov)
  );

  alu_bitops #(.DATA_W(DATA_W), .NIB_W(HALF_W)) u_bitops (
    .a   (acc_in),
    .b   (src_in),
    .cin (flags_q.cy),
    .op  (op),
    .res (bit_res),
    .cy  (bit_cy)
  );

  alu_decadj #(.DATA_W(DATA_W), .NIB_W(HALF_W)) u_decadj (
    .a      (acc_in),
    .cy_in  (flags_q.cy),
    .ac_in  (flags_q.ac),
    .res    (da_res),
    .cy_out (da_cy)
  );

  // Result select and next-flag select
  always_comb begin
    result  = bit_res;
    flags_d = flags_q;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        result     = arith_res;
        flags_d.cy = arith_cy;
        flags_d.ac = arith_ac;
        flags_d.ov = arith_ov;
      end
      OP_DA: begin
        result     = da_res;
        flags_d.cy = da_cy;
      end
      OP_RRC, OP_RLC: begin
        flags_d.cy = bit_cy;
      end
      default: begin
        result = bit_res;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (exec_en) begin
      flags_q <= flags_d;
    end
  end

  assign cy_flag = flags_q.cy;
  assign ac_flag = flags_q.ac;
  assign ov_flag = flags_q.ov;

  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(flags_q)); // R12

  AST_INCDEC_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op == OP_INC || op == OP_DEC) |=> $stable(flags_q)); // R11

  AST_LOGIC_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op inside {OP_AND, OP_OR, OP_XOR, OP_CPL, OP_RR, OP_RL, OP_SWAP, OP_PASS})
    |=> $stable(flags_q)); // R5

  AST_DA_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == OP_DA && flags_q.cy |=> flags_q.cy); // R10

  AST_RRC_LSB_TO_CY: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == OP_RRC |=> flags_q.cy == $past(acc_in[0])); // R7

  AST_RLC_MSB_TO_CY: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == OP_RLC |=> flags_q.cy == $past(acc_in[DATA_W-1])); // R7

  AST_ADD_MIXED_SIGN_NO_OV: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op == OP_ADD || op == OP_ADDC) && (acc_in[DATA_W-1] != src_in[DATA_W-1])
    |=> !flags_q.ov); // R3

endmodule

// File: tb/test_acc_alu_unit.sv
module test_acc_alu_unit;

  logic       clk;
  logic       rst_n;
  logic       exec_en;
  logic [3:0] op_sel;
  logic [7:0] acc_in;
  logic [7:0] src_in;
  logic [7:0] result;
  logic       cy_flag;
  logic       ac_flag;
  logic       ov_flag;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;
  bit  m_cy = 0;
  bit  m_ac = 0;
  bit  m_ov = 0;

  acc_alu_unit i_acc_alu_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_en (exec_en),
    .op_sel  (op_sel),
    .acc_in  (acc_in),
    .src_in  (src_in),
    .result  (result),
    .cy_flag (cy_flag),
    .ac_flag (ac_flag),
    .ov_flag (ov_flag)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic int sx(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic string res_tag(input int op);
    case (op)
      0, 1:        return "R2";
      2:           return "R4";
      3, 4, 5, 6:  return "R5";
      7, 8:        return "R6";
      9, 10:       return "R7";
      11:          return "R8";
      12:          return "R9";
      13, 14:      return "R11";
      default:     return "R13";
    endcase
  endfunction

  function automatic string flag_tag(input int op, input bit en);
    if (!en) return "R12";
    case (op)
      0, 1:    return "R3";
      2:       return "R4";
      9, 10:   return "R7";
      12:      return "R10";
      default: return res_tag(op);
    endcase
  endfunction

  task automatic model(input int op, input int a, input int b,
                       input bit c, input bit h, input bit v,
                       output int r, output bit nc, output bit nh, output bit nv);
    int ci = c;
    int s;
    nc = c; nh = h; nv = v; r = a;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        s  = a + b + ci;
        r  = s & 255;
        nc = (s > 255);
        nh = ((a & 15) + (b & 15) + ci) > 15;
        s  = sx(a) + sx(b) + ci;
        nv = (s > 127) || (s < -128);
      end
      2: begin
        s  = a - b - ci;
        r  = s & 255;
        nc = (s < 0);
        nh = ((a & 15) - (b & 15) - ci) < 0;
        s  = sx(a) - sx(b) - ci;
        nv = (s > 127) || (s < -128);
      end
      3:  r = a & b;
      4:  r = a | b;
      5:  r = a ^ b;
      6:  r = 255 - a;
      7:  r = (a >> 1) | ((a & 1) << 7);
      8:  r = ((a << 1) | (a >> 7)) & 255;
      9:  begin r = (a >> 1) | (ci << 7); nc = a[0]; end
      10: begin r = ((a << 1) | ci) & 255; nc = (a >> 7) != 0; end
      11: r = ((a << 4) | (a >> 4)) & 255;
      12: begin
        s = a;
        if ((a & 15) > 9 || h) s = s + 6;
        if (((s >> 4) & 15) > 9 || c || s > 255) s = s + 96;
        nc = c || (s > 255);
        r  = s & 255;
      end
      13: r = (a + 1) & 255;
      14: r = (a + 255) & 255;
      default: r = a;
    endcase
  endtask

  task automatic do_op(input int op, input int a, input int b, input bit en);
    int r; bit ec, eh, ev;
    model(op, a, b, m_cy, m_ac, m_ov, r, ec, eh, ev);
    @(negedge clk);
    op_sel  = op[3:0];
    acc_in  = a[7:0];
    src_in  = b[7:0];
    exec_en = en;
    #1;
    n_checks++;
    if (result !== r[7:0]) begin
      n_errors++;
      $display("FAIL %s op=%0d a=%h b=%h: result actual %h expected %h",
               res_tag(op), op, a[7:0], b[7:0], result, r[7:0]);
    end
    @(posedge clk);
    #1;
    if (en) begin m_cy = ec; m_ac = eh; m_ov = ev; end
    n_checks++;
    if ({cy_flag, ac_flag, ov_flag} !== {m_cy, m_ac, m_ov}) begin
      n_errors++;
      $display("FAIL %s op=%0d a=%h b=%h: flags cy/ac/ov actual %b expected %b",
               flag_tag(op, en), op, a[7:0], b[7:0],
               {cy_flag, ac_flag, ov_flag}, {m_cy, m_ac, m_ov});
    end
  endtask

  // Reach each (CY, AC) pair with an add: 0 -> 00, 1 -> 01, 2 -> 10, 3 -> 11
  task automatic prime(input int st);
    case (st)
      0: do_op(0, 8'h00, 8'h00, 1);
      1: do_op(0, 8'h08, 8'h08, 1);
      2: do_op(0, 8'h80, 8'h80, 1);
      default: do_op(0, 8'hFF, 8'h01, 1);
    endcase
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    int bl[8];
    rst_n = 0; exec_en = 0; op_sel = 0; acc_in = 0; src_in = 0;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if ({cy_flag, ac_flag, ov_flag} !== 3'b000) begin
      n_errors++;
      $display("FAIL R1 reset flags actual %b expected 000", {cy_flag, ac_flag, ov_flag});
    end
    @(negedge clk);
    rst_n = 1;

    // Arithmetic: every accumulator value, edge and mixed operands, all flag entries
    for (int op = 0; op < 3; op++) begin
      for (int st = 0; st < 4; st++) begin
        for (int a = 0; a < 256; a++) begin
          bl[0] = 0; bl[1] = 1; bl[2] = 15; bl[3] = 127;
          bl[4] = 128; bl[5] = 255; bl[6] = (a * 7 + 13) & 255; bl[7] = a ^ 8'h5A;
          for (int k = 0; k < 8; k++) begin
            prime(st);
            do_op(op, a, bl[k], 1);
          end
        end
      end
    end

    // Logic, rotates, swap, decimal adjust, inc/dec, pass under all flag entries
    for (int op = 3; op < 16; op++) begin
      for (int st = 0; st < 4; st++) begin
        for (int a = 0; a < 256; a++) begin
          prime(st);
          do_op(op, a, (a * 37 + 91) & 255, 1);
        end
      end
    end

    // Flags must hold while exec_en is low (R12)
    for (int a = 0; a < 256; a++) begin
      prime(a % 4);
      do_op(a % 16, a, 255 - a, 0);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run state actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule